// File: doc/BRIEF.md
# Processor Control Sequencer

This block is the control state machine of a small multi-cycle RV32 core. It steps the core through starting up, fetching, decoding and executing instructions, and through the waits for loads, stores, multiply/divide and wait-for-interrupt. Each state drives a few control strobes. The datapath, the register file, the ALU and the memories sit outside the block. The block only reads their condition flags and done strobes, and tells them when to pause, when to load the program counter, when to restart fetching and when to enter a trap.

The state is held one-hot, and each next-state bit is computed on its own. After any taken branch, return-from-trap (mret) or trap, the machine goes back to a fetch-restart state. A misaligned branch target, or a misaligned data access, goes first to an exception state and then to a reinit state before fetching starts again.

Top module: `proc_seq`

## Requirements
- R1: `state_o` holds exactly one set bit in every cycle. The bit positions are: 0 idle, 1 fetch-restart, 2 fetch, 3 decode, 4 fetch/execute, 5 exception, 6 exception-reinit, 7 decode-data, 8 wfi, 9 wfi-wait, 10 load, 11 load-wait, 12 store, 13 store-wait, 14 mul/div.
- R2: In idle, `paused_o` is high. The machine stays in idle while `start_i` is low. When `start_i` is high, `pc_init_o` is high in that same cycle, and the next state is fetch-restart.
- R3: In the cycle after `pc_init_o` is high, `fetch_addr_o` equals `start_addr_i` from the cycle before, with bit 0 cleared. At other times it holds its value.
- R4: Fetch-restart goes to fetch, fetch goes to decode, and decode goes to fetch/execute, each without any condition. `fetch_start_o` is high only in fetch-restart.
- R5: Fetch/execute goes to exception when any of these holds: `timer_i`, `irq_i` and `ecall_i` are all high; `branch_i` is high with `br_tgt_lo_i[1]` set; or `exc_i` is high with `data_acc_en_i` high.
- R6: In fetch/execute, the exception transition takes priority over a restart. Otherwise, `branch_i` or `mret_i` leads to fetch-restart, and anything else leads to decode-data.
- R7: Decode-data dispatches in this priority order: `is_wfi_i` to wfi, then `is_store_i` to store, then `is_load_i` to load, then `is_muldiv_i` to mul/div. When none of these is set, it returns to fetch/execute.
- R8: Load goes to load-wait. Load-wait goes to exception on `ld_misalign_i`, otherwise to fetch/execute on `ld_done_i`, and otherwise stays.
- R9: Store goes to store-wait. Store-wait goes to exception on `st_misalign_i`, otherwise to fetch/execute on `st_done_i`, and otherwise stays.
- R10: Mul/div stays until `md_done_i` is high, then goes to fetch/execute.
- R11: Wfi goes to wfi-wait. Wfi-wait stays until `timer_i` and `irq_i` are both high, then goes to exception.
- R12: Exception always goes to exception-reinit, which always goes to fetch-restart. `exc_entry_o` is high only in the exception state.
- R13: Driving `rst_ni` low forces the idle state and a zero `fetch_addr_o` at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request |
| start_addr_i | input | ADDR_W | Boot address |
| is_load_i | input | 1 | Decoded load |
| is_store_i | input | 1 | Decoded store |
| is_wfi_i | input | 1 | Decoded wait-for-interrupt |
| is_muldiv_i | input | 1 | Decoded multiply/divide |
| branch_i | input | 1 | Taken branch or jump |
| mret_i | input | 1 | Return from trap active |
| br_tgt_lo_i | input | 2 | Low bits of the branch target |
| ld_misalign_i | input | 1 | Load address misaligned |
| st_misalign_i | input | 1 | Store address misaligned |
| ld_done_i | input | 1 | Load complete |
| st_done_i | input | 1 | Store complete |
| md_done_i | input | 1 | Mul/div complete |
| timer_i | input | 1 | Timer condition |
| irq_i | input | 1 | Interrupt condition |
| ecall_i | input | 1 | Environment call |
| exc_i | input | 1 | Exception raised by the datapath |
| data_acc_en_i | input | 1 | Data access enabled |
| state_o | output | 15 | One-hot current state |
| paused_o | output | 1 | Core paused (idle) |
| pc_init_o | output | 1 | Load the PC from the boot address |
| fetch_start_o | output | 1 | Restart instruction fetch |
| exc_entry_o | output | 1 | Trap entry |
| fetch_addr_o | output | ADDR_W | Latched fetch start address |

## Verification
Directed sequences come first. They hold `start_i` low for several cycles, then use an odd boot address to check that bit 0 is cleared. They then set the fetch/execute inputs so that an exception and a branch occur together, which shows whether the exception wins over the restart. They also set every decode flag at once, which shows the dispatch priority. A long stretch of random inputs follows. In this stretch, done strobes and misalign flags arrive in the same cycle, so the bench can tell a misalign exit from a completion exit in both wait states. Timer and interrupt are driven independently, so wfi-wait is seen staying put as well as leaving. A reset in the middle of the run checks that the return to idle is asynchronous and clears the latched address.

// File: rtl/proc_seq_pkg.sv
package proc_seq_pkg;
  localparam int NUM_ST = 15;
  localparam int S_IDLE     = 0;
  localparam int S_RESTART  = 1;
  localparam int S_FETCH    = 2;
  localparam int S_DECODE   = 3;
  localparam int S_FEXE     = 4;
  localparam int S_EXC      = 5;
  localparam int S_REINIT   = 6;
  localparam int S_DDATA    = 7;
  localparam int S_WFI      = 8;
  localparam int S_WFI_WAIT = 9;
  localparam int S_LD       = 10;
  localparam int S_LD_WAIT  = 11;
  localparam int S_ST       = 12;
  localparam int S_ST_WAIT  = 13;
  localparam int S_MD       = 14;

  typedef logic [NUM_ST-1:0] st_vec_t;

  typedef struct packed {
    logic start;
    logic is_load;
    logic is_store;
    logic is_wfi;
    logic is_muldiv;
    logic branch;
    logic mret;
    logic tgt_b1;
    logic ld_mis;
    logic st_mis;
    logic ld_done;
    logic st_done;
    logic md_done;
    logic timer;
    logic irq;
    logic ecall;
    logic exc;
    logic dacc;
  } seq_cond_t;
endpackage

// File: rtl/seq_next.sv
module seq_next
  import proc_seq_pkg::*;
(
  input  st_vec_t   cur_i,
  input  seq_cond_t c_i,
  output st_vec_t   nxt_o
);
  logic fexe_trap;
  logic restart;

  // any of the three trap sources seen in fetch/execute
  assign fexe_trap = (c_i.timer & c_i.irq & c_i.ecall)
                   | (c_i.branch & c_i.tgt_b1)
                   | (c_i.exc & c_i.dacc);
  assign restart = c_i.branch | c_i.mret;

  always_comb begin
    nxt_o = '0;
    if (cur_i[S_IDLE]) begin
      if (c_i.start) nxt_o[S_RESTART] = 1'b1;
      else           nxt_o[S_IDLE]    = 1'b1;
    end
    if (cur_i[S_RESTART]) nxt_o[S_FETCH]  = 1'b1;
    if (cur_i[S_FETCH])   nxt_o[S_DECODE] = 1'b1;
    if (cur_i[S_DECODE])  nxt_o[S_FEXE]   = 1'b1;
    if (cur_i[S_FEXE]) begin
      if (fexe_trap)    nxt_o[S_EXC]     = 1'b1;
      else if (restart) nxt_o[S_RESTART] = 1'b1;
      else              nxt_o[S_DDATA]   = 1'b1;
    end
    if (cur_i[S_DDATA]) begin
      if (c_i.is_wfi)         nxt_o[S_WFI]  = 1'b1;
      else if (c_i.is_store)  nxt_o[S_ST]   = 1'b1;
      else if (c_i.is_load)   nxt_o[S_LD]   = 1'b1;
      else if (c_i.is_muldiv) nxt_o[S_MD]   = 1'b1;
      else                    nxt_o[S_FEXE] = 1'b1;
    end
    if (cur_i[S_WFI]) nxt_o[S_WFI_WAIT] = 1'b1;
    if (cur_i[S_WFI_WAIT]) begin
      if (c_i.timer & c_i.irq) nxt_o[S_EXC]      = 1'b1;
      else                     nxt_o[S_WFI_WAIT] = 1'b1;
    end
    if (cur_i[S_LD]) nxt_o[S_LD_WAIT] = 1'b1;
    if (cur_i[S_LD_WAIT]) begin
      if (c_i.ld_mis)       nxt_o[S_EXC]     = 1'b1;
      else if (c_i.ld_done) nxt_o[S_FEXE]    = 1'b1;
      else                  nxt_o[S_LD_WAIT] = 1'b1;
    end
    if (cur_i[S_ST]) nxt_o[S_ST_WAIT] = 1'b1;
    if (cur_i[S_ST_WAIT]) begin
      if (c_i.st_mis)       nxt_o[S_EXC]     = 1'b1;
      else if (c_i.st_done) nxt_o[S_FEXE]    = 1'b1;
      else                  nxt_o[S_ST_WAIT] = 1'b1;
    end
    if (cur_i[S_MD]) begin
      if (c_i.md_done) nxt_o[S_FEXE] = 1'b1;
      else             nxt_o[S_MD]   = 1'b1;
    end
    if (cur_i[S_EXC])    nxt_o[S_REINIT]  = 1'b1;
    if (cur_i[S_REINIT]) nxt_o[S_RESTART] = 1'b1;
  end
endmodule

// File: rtl/seq_state_reg.sv
module seq_state_reg
  import proc_seq_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  st_vec_t nxt_i,
  input  logic    md_done_i,
  input  logic    start_i,
  output st_vec_t cur_o
);
  localparam st_vec_t RST_VEC = st_vec_t'(1) << S_IDLE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cur_o <= RST_VEC;
    else         cur_o <= nxt_i;
  end

  a_r1_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(cur_o) == 1);
  a_r2_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_o[S_IDLE] && !start_i) |=> cur_o[S_IDLE]);
  a_r10_md_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_o[S_MD] && !md_done_i) |=> cur_o[S_MD]);
  a_r12_exc_reinit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cur_o[S_EXC] |=> cur_o[S_REINIT]);
  a_r12_reinit_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cur_o[S_REINIT] |=> cur_o[S_RESTART]);
endmodule

// File: rtl/seq_outputs.sv
module seq_outputs
  import proc_seq_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  st_vec_t           cur_i,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  output logic              paused_o,
  output logic              pc_init_o,
  output logic              fetch_start_o,
  output logic              exc_entry_o,
  output logic [ADDR_W-1:0] fetch_addr_o
);
  assign paused_o      = cur_i[S_IDLE];
  assign pc_init_o     = cur_i[S_IDLE] & start_i;
  assign fetch_start_o = cur_i[S_RESTART];
  assign exc_entry_o   = cur_i[S_EXC];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        fetch_addr_o <= '0;
    else if (pc_init_o) fetch_addr_o <= {start_addr_i[ADDR_W-1:1], 1'b0};
  end

  a_r3_addr_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_init_o |=> (fetch_addr_o[ADDR_W-1:1] == $past(start_addr_i[ADDR_W-1:1])
                   && !fetch_addr_o[0]));
  a_r3_addr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pc_init_o |=> $stable(fetch_addr_o));
endmodule

// File: rtl/proc_seq.sv
module proc_seq
  import proc_seq_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic              is_load_i,
  input  logic              is_store_i,
  input  logic              is_wfi_i,
  input  logic              is_muldiv_i,
  input  logic              branch_i,
  input  logic              mret_i,
  input  logic [1:0]        br_tgt_lo_i,
  input  logic              ld_misalign_i,
  input  logic              st_misalign_i,
  input  logic              ld_done_i,
  input  logic              st_done_i,
  input  logic              md_done_i,
  input  logic              timer_i,
  input  logic              irq_i,
  input  logic              ecall_i,
  input  logic              exc_i,
  input  logic              data_acc_en_i,
  output logic [NUM_ST-1:0] state_o,
  output logic              paused_o,
  output logic              pc_init_o,
  output logic              fetch_start_o,
  output logic              exc_entry_o,
  output logic [ADDR_W-1:0] fetch_addr_o
);
  seq_cond_t cond;
  st_vec_t   cur, nxt;
  logic      unused_b0;

  assign unused_b0 = br_tgt_lo_i[0];

  always_comb begin
    cond.start     = start_i;
    cond.is_load   = is_load_i;
    cond.is_store  = is_store_i;
    cond.is_wfi    = is_wfi_i;
    cond.is_muldiv = is_muldiv_i;
    cond.branch    = branch_i;
    cond.mret      = mret_i;
    cond.tgt_b1    = br_tgt_lo_i[1];
    cond.ld_mis    = ld_misalign_i;
    cond.st_mis    = st_misalign_i;
    cond.ld_done   = ld_done_i;
    cond.st_done   = st_done_i;
    cond.md_done   = md_done_i;
    cond.timer     = timer_i;
    cond.irq       = irq_i;
    cond.ecall     = ecall_i;
    cond.exc       = exc_i;
    cond.dacc      = data_acc_en_i;
  end

  seq_next u_next (
    .cur_i (cur),
    .c_i   (cond),
    .nxt_o (nxt)
  );

  seq_state_reg u_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .nxt_i     (nxt),
    .md_done_i (md_done_i),
    .start_i   (start_i),
    .cur_o     (cur)
  );

  seq_outputs #(.ADDR_W(ADDR_W)) u_out (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .cur_i         (cur),
    .start_i       (start_i),
    .start_addr_i  (start_addr_i),
    .paused_o      (paused_o),
    .pc_init_o     (pc_init_o),
    .fetch_start_o (fetch_start_o),
    .exc_entry_o   (exc_entry_o),
    .fetch_addr_o  (fetch_addr_o)
  );

  assign state_o = cur;

  a_r5_trap_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur[S_FEXE] && ((timer_i && irq_i && ecall_i) || (branch_i && br_tgt_lo_i[1])
                     || (exc_i && data_acc_en_i))) |=> exc_entry_o);
  a_r11_wfi_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur[S_WFI_WAIT] && timer_i && irq_i) |=> exc_entry_o);
  a_r8_ld_misalign: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur[S_LD_WAIT] && ld_misalign_i) |=> exc_entry_o);
  a_r9_st_misalign: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur[S_ST_WAIT] && st_misalign_i) |=> exc_entry_o);
endmodule

// File: tb/proc_seq_tb_top.sv
`timescale 1ns/1ps
module proc_seq_tb_top;
  localparam int AW = 32;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start, ld, st, wfi, md, br, mret, ldm, stm, ldd, std, mdd;
  logic tmr, irq, ecall, exc, dacc;
  logic [1:0] tgt;
  logic [AW-1:0] saddr;
  logic [14:0] state;
  logic paused, pc_init, fstart, exc_entry;
  logic [AW-1:0] faddr;

  int n_cmp = 0;
  int n_bad = 0;
  int m_st = 0;
  logic [AW-1:0] m_addr = '0;
  bit done_run = 0;

  always #10 clk = ~clk;

  proc_seq #(.ADDR_W(AW)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start), .start_addr_i(saddr),
    .is_load_i(ld), .is_store_i(st), .is_wfi_i(wfi), .is_muldiv_i(md),
    .branch_i(br), .mret_i(mret), .br_tgt_lo_i(tgt),
    .ld_misalign_i(ldm), .st_misalign_i(stm), .ld_done_i(ldd), .st_done_i(std),
    .md_done_i(mdd), .timer_i(tmr), .irq_i(irq), .ecall_i(ecall), .exc_i(exc),
    .data_acc_en_i(dacc), .state_o(state), .paused_o(paused), .pc_init_o(pc_init),
    .fetch_start_o(fstart), .exc_entry_o(exc_entry), .fetch_addr_o(faddr));

  function automatic string req_of(int s);
    case (s)
      0: return "R2";
      1, 2, 3: return "R4";
      4: return "R5/R6";
      5, 6: return "R12";
      7: return "R7";
      8, 9: return "R11";
      10, 11: return "R8";
      12, 13: return "R9";
      default: return "R10";
    endcase
  endfunction

  function automatic int model_next(int s);
    case (s)
      0: return start ? 1 : 0;
      1: return 2;
      2: return 3;
      3: return 4;
      4: begin
        if ((tmr && irq && ecall) || (br && tgt[1]) || (exc && dacc)) return 5;
        if (br || mret) return 1;
        return 7;
      end
      5: return 6;
      6: return 1;
      7: begin
        if (wfi) return 8;
        if (st) return 12;
        if (ld) return 10;
        if (md) return 14;
        return 4;
      end
      8: return 9;
      9: return (tmr && irq) ? 5 : 9;
      10: return 11;
      11: return ldm ? 5 : (ldd ? 4 : 11);
      12: return 13;
      13: return stm ? 5 : (std ? 4 : 13);
      default: return mdd ? 4 : 14;
    endcase
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h (model state %0d)", req, act, exp, m_st);
    end
  endtask

  task automatic check_all();
    chk($countones(state) == 1, "R1", 64'(state), 64'(15'(1) << m_st));
    chk(state == (15'(1) << m_st), req_of(m_st), 64'(state), 64'(15'(1) << m_st));
    chk(paused == (m_st == 0), "R2", 64'(paused), 64'(m_st == 0));
    chk(pc_init == (m_st == 0 && start), "R2", 64'(pc_init), 64'(m_st == 0 && start));
    chk(fstart == (m_st == 1), "R4", 64'(fstart), 64'(m_st == 1));
    chk(exc_entry == (m_st == 5), "R12", 64'(exc_entry), 64'(m_st == 5));
    chk(faddr == m_addr, "R3", 64'(faddr), 64'(m_addr));
  endtask

  // inputs already driven; check now, then advance one clock
  task automatic step();
    int nx;
    #1;
    check_all();
    nx = model_next(m_st);
    if (m_st == 0 && start) m_addr = {saddr[AW-1:1], 1'b0};
    @(negedge clk);
    m_st = nx;
  endtask

  task automatic clear_in();
    {start, ld, st, wfi, md, br, mret, ldm, stm, ldd, std, mdd} = '0;
    {tmr, irq, ecall, exc, dacc} = '0;
    tgt = 2'b00;
    saddr = '0;
  endtask

  task automatic rand_in();
    start = ($urandom_range(3) == 0);
    saddr = $urandom;
    ld = $urandom_range(1); st = ($urandom_range(3) == 0);
    wfi = ($urandom_range(7) == 0); md = $urandom_range(1);
    br = ($urandom_range(3) == 0); mret = ($urandom_range(5) == 0);
    tgt = 2'($urandom_range(3));
    ldm = ($urandom_range(7) == 0); stm = ($urandom_range(7) == 0);
    ldd = $urandom_range(1); std = $urandom_range(1); mdd = ($urandom_range(2) == 0);
    tmr = $urandom_range(1); irq = $urandom_range(1); ecall = ($urandom_range(3) == 0);
    exc = ($urandom_range(3) == 0); dacc = $urandom_range(1);
  endtask

  initial begin
    clear_in();
    repeat (3) @(negedge clk);
    #1;
    // R13: reset state before release
    chk(state == 15'(1), "R13", 64'(state), 64'd1);
    chk(faddr == '0, "R13", 64'(faddr), 64'd0);
    @(negedge clk);
    rst_ni = 1'b1;
    m_st = 0; m_addr = '0;
    // R2: hold idle with start low
    repeat (4) step();
    // R3: odd boot address
    start = 1'b1; saddr = 32'h8000_0113;
    step();
    clear_in();
    step(); step(); step();          // restart, fetch, decode (R4)
    // R6: branch with misaligned target plus mret -> exception wins
    br = 1'b1; mret = 1'b1; tgt = 2'b10;
    step();
    clear_in();
    step(); step(); step(); step(); step();  // exc, reinit, restart, fetch, decode
    // R6: plain branch restarts
    br = 1'b1; tgt = 2'b01;
    step();
    clear_in();
    step(); step(); step();
    // R7: all flags at once -> wfi
    step();                          // fexe -> ddata
    {wfi, st, ld, md} = 4'b1111;
    step();
    clear_in();
    step();                          // wfi -> wfi-wait
    tmr = 1'b1; step(); step();      // R11: timer alone holds
    irq = 1'b1; step();              // R11: exit to exception
    clear_in();
    // random phase
    for (int i = 0; i < 5000; i++) begin
      rand_in();
      step();
    end
    // R13: asynchronous reset mid-run
    clear_in();
    #3 rst_ni = 1'b0;
    #1;
    chk(state == 15'(1), "R13", 64'(state), 64'd1);
    chk(faddr == '0, "R13", 64'(faddr), 64'd0);
    m_st = 0; m_addr = '0;
    @(negedge clk);
    rst_ni = 1'b1;
    repeat (2) step();
    done_run = 1;
  end

  initial begin
    fork
      wait (done_run);
      begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog act=running exp=finished");
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule